// File: doc/BRIEF.md
# Oversampled Serial Receiver with Flow-Controlled Clear-to-Send

This block receives asynchronous serial characters. A baud tick at sixteen times the bit rate paces it. It validates each start bit at mid-bit and assembles 7- or 8-bit characters least significant bit first. It can check an optional parity bit and always checks the first stop bit. Each character is stored with its two error flags in an internal 32-entry receive queue. The reader sees the oldest entry on the read port and removes it with a one-cycle read strobe.

The block also drives an active-low clear-to-send output. In manual mode that output follows a software request bit. In automatic mode the receiver controls it. When the queue already holds the trigger-level count and the start bit of one more character has been validated, the output is driven high (negated). Reception continues after that, and characters are stored until the queue is actually full. The output is driven low again once the count falls below the trigger level.

The receive state machine has five states. IDLE waits for an armed high-to-low edge. START checks the line at tick 8: a low line validates the start bit and moves to DATA, a high line returns to IDLE. DATA samples one bit every 16 ticks. After the last data bit it goes to PARITY if parity is enabled, otherwise to STOP. PARITY samples one bit and goes to STOP. STOP samples the stop level, stores the character and returns to IDLE. Deasserting the receive enable forces IDLE from any state.

Top module: `uart_rx_cts`

## Requirements
- R1: After reset, `cts_n` is 1, the queue is empty (`fifo_empty`=1, `fifo_count`=0) and `overrun` is 0.
- R2: With `cts_auto`=0, `cts_n` equals the inverse of `cts_sw`. With `cts_auto`=1, `cts_sw` has no effect on `cts_n`.
- R3: With `cts_auto`=1, `cts_n` goes to 1 the cycle after a start bit is validated while `fifo_count` is at or above `trig_lvl`. It stays 0 while the count is below the trigger level and no such start occurs.
- R4: After `cts_n` has been negated, incoming characters are still stored until `fifo_count` reaches 32.
- R5: With `cts_auto`=1, `cts_n` returns to 0 the cycle after `fifo_count` is below `trig_lvl`.
- R6: A character is accepted only after the line has been seen high while `rx_en`=1 and then falls. A line that is already low when the receiver is enabled, however long it stays low, stores nothing. A low pulse that has ended before the tick-8 start sample stores nothing.
- R7: Data bits arrive least significant bit first. With `word8`=1 eight bits are stored. With `word8`=0 seven bits are received and bit 7 of `rd_data` reads 0.
- R8: `rd_frm_err` is 1 exactly when the first stop-bit sample is low. Additional stop bits at high level are accepted without error.
- R9: With `par_en`=1, one parity bit follows the data. `par_odd`=0 expects an even count of ones over data plus parity, and `par_odd`=1 expects an odd count. A mismatch sets `rd_par_err`. With `par_en`=0 no parity bit is expected and `rd_par_err` is 0.
- R10: A character that completes while the queue holds 32 entries is discarded. `overrun` pulses for one cycle and the stored entries are unchanged.
- R11: The read port shows the oldest entry (first-word fall-through). `rd_en`=1 on a non-empty queue removes that entry at the next clock edge, so characters read out in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rx_en | input | 1 | Receiver enable |
| rx_in | input | 1 | Serial line, idle high |
| word8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| par_en | input | 1 | Parity bit expected and checked |
| par_odd | input | 1 | 1: odd parity, 0: even parity |
| cts_auto | input | 1 | 1: receiver drives `cts_n`, 0: `cts_sw` drives it |
| cts_sw | input | 1 | Software clear-to-send request (1 drives `cts_n` low) |
| trig_lvl | input | 6 | Queue count at which automatic flow control halts the sender |
| rd_en | input | 1 | Remove the oldest entry |
| rd_data | output | 8 | Oldest character |
| rd_par_err | output | 1 | Parity error flag of the oldest character |
| rd_frm_err | output | 1 | Framing error flag of the oldest character |
| fifo_empty | output | 1 | Queue holds no entry |
| fifo_count | output | 6 | Number of stored entries, 0 to 32 |
| overrun | output | 1 | One-cycle pulse when a character is discarded |
| cts_n | output | 1 | Active-low clear-to-send |

## Verification
Two events can fall on the same clock edge: storing a finished character and the full-queue decision. A character can complete exactly when the queue holds 32 entries. The bench sets this up by stopping reads, letting automatic flow control negate `cts_n`, and sending one character more than the queue can hold. It judges the outcome by three results: exactly one `overrun` pulse, a count that stays at 32, and a readback of the 32 stored characters in order with the surplus one missing. A second overlap is the start-bit validation and the trigger comparison. Here `cts_n` must stay low for the character that brings the count up to the trigger level and must rise only on the start of the next one.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PARITY,
        S_STOP
    } rx_state_t;

    typedef struct packed {
        logic       frm_err;
        logic       par_err;
        logic [7:0] data;
    } rx_char_t;

    localparam int CHAR_W = $bits(rx_char_t);
endpackage

// File: rtl/uart_rx_fsm.sv
module uart_rx_fsm
    import uart_rx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     baud_tick,
    input  logic     rx_en,
    input  logic     rx_s,
    input  logic     word8,
    input  logic     par_en,
    input  logic     par_odd,
    output logic     start_ok,
    output logic     push,
    output rx_char_t push_char
);
    localparam int TW  = $clog2(OSR);
    localparam int MID = OSR / 2 - 1;
    localparam int END = OSR - 1;

    rx_state_t      state, state_nx;
    logic [TW-1:0]  tcnt;
    logic [2:0]     bidx;
    logic [7:0]     shreg;
    logic           pbit;
    logic           armed;
    logic [7:0]     data_asm;
    logic           last_bit;
    logic           at_mid, at_end;

    assign at_mid   = baud_tick && (tcnt == TW'(MID));
    assign at_end   = baud_tick && (tcnt == TW'(END));
    assign last_bit = word8 ? (bidx == 3'd7) : (bidx == 3'd6);
    assign data_asm = word8 ? shreg : {1'b0, shreg[7:1]};

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (armed && !rx_s) state_nx = S_START;
            S_START:  if (at_mid) state_nx = rx_s ? S_IDLE : S_DATA;
            S_DATA:   if (at_end && last_bit) state_nx = par_en ? S_PARITY : S_STOP;
            S_PARITY: if (at_end) state_nx = S_STOP;
            S_STOP:   if (at_end) state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
        if (!rx_en) state_nx = S_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt  <= '0;
            bidx  <= '0;
            shreg <= '0;
            pbit  <= 1'b0;
            armed <= 1'b0;
        end else begin
            if (!rx_en) begin
                armed <= 1'b0;
            end else if (state == S_IDLE) begin
                if (rx_s) armed <= 1'b1;
                else if (armed) armed <= 1'b0;
            end
            if (state != state_nx) begin
                tcnt <= '0;
            end else if (baud_tick && state != S_IDLE) begin
                tcnt <= (state == S_DATA && at_end) ? '0 : tcnt + 1'b1;
            end
            if (state == S_DATA && at_end) begin
                shreg <= {rx_s, shreg[7:1]};
                bidx  <= last_bit ? 3'd0 : bidx + 3'd1;
            end
            if (state == S_IDLE) bidx <= '0;
            if (state == S_PARITY && at_end) pbit <= rx_s;
        end
    end

    always_comb begin
        start_ok           = (state == S_START) && at_mid && !rx_s && rx_en;
        push               = (state == S_STOP) && at_end && rx_en;
        push_char.data     = data_asm;
        push_char.frm_err  = !rx_s;
        push_char.par_err  = par_en && ((^data_asm ^ pbit) != par_odd);
    end
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     push,
    input  rx_char_t                 wdata,
    input  logic                     pop,
    output rx_char_t                 rdata,
    output logic                     empty,
    output logic [$clog2(DEPTH):0]   count,
    output logic                     overrun
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    rx_char_t        mem [DEPTH];
    logic [AW-1:0]   wptr, rptr;
    logic            do_pop, do_push, full;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign rdata   = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr    <= '0;
            rptr    <= '0;
            count   <= '0;
            overrun <= 1'b0;
        end else begin
            overrun <= push && !do_push;
            if (do_push) wptr <= wptr + 1'b1;
            if (do_pop)  rptr <= rptr + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/uart_rx_cts_ctl.sv
module uart_rx_cts_ctl #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cts_auto,
    input  logic          cts_sw,
    input  logic [CW-1:0] trig_lvl,
    input  logic [CW-1:0] count,
    input  logic          start_ok,
    output logic          cts_n
);
    logic halt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   halt <= 1'b0;
        else if (!cts_auto)           halt <= 1'b0;
        else if (count < trig_lvl)    halt <= 1'b0;
        else if (start_ok)            halt <= 1'b1;
    end

    assign cts_n = cts_auto ? halt : !cts_sw;
endmodule

// File: rtl/uart_rx_cts.sv
module uart_rx_cts
    import uart_rx_pkg::*;
#(
    parameter int OSR   = 16,
    parameter int DEPTH = 32,
    parameter int CW    = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          baud_tick,
    input  logic          rx_en,
    input  logic          rx_in,
    input  logic          word8,
    input  logic          par_en,
    input  logic          par_odd,
    input  logic          cts_auto,
    input  logic          cts_sw,
    input  logic [CW-1:0] trig_lvl,
    input  logic          rd_en,
    output logic [7:0]    rd_data,
    output logic          rd_par_err,
    output logic          rd_frm_err,
    output logic          fifo_empty,
    output logic [CW-1:0] fifo_count,
    output logic          overrun,
    output logic          cts_n
);
    logic [1:0] sync;
    logic       rx_s;
    logic       start_ok, push;
    rx_char_t   push_char, head;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync <= 2'b11;
        else        sync <= {sync[0], rx_in};
    end
    assign rx_s = sync[1];

    uart_rx_fsm #(.OSR(OSR)) u_fsm (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rx_en(rx_en),
        .rx_s(rx_s), .word8(word8), .par_en(par_en), .par_odd(par_odd),
        .start_ok(start_ok), .push(push), .push_char(push_char)
    );

    uart_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .wdata(push_char),
        .pop(rd_en), .rdata(head), .empty(fifo_empty),
        .count(fifo_count), .overrun(overrun)
    );

    uart_rx_cts_ctl #(.CW(CW)) u_cts (
        .clk(clk), .rst_n(rst_n), .cts_auto(cts_auto), .cts_sw(cts_sw),
        .trig_lvl(trig_lvl), .count(fifo_count), .start_ok(start_ok),
        .cts_n(cts_n)
    );

    assign rd_data    = head.data;
    assign rd_par_err = head.par_err;
    assign rd_frm_err = head.frm_err;
endmodule

// File: rtl/uart_rx_cts_chk.sv
module uart_rx_cts_chk #(
    parameter int DEPTH = 32,
    parameter int CW    = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cts_auto,
    input logic          cts_n,
    input logic [CW-1:0] trig_lvl,
    input logic [CW-1:0] fifo_count,
    input logic          start_ok,
    input logic          push,
    input logic [7:0]    push_data,
    input logic          word8,
    input logic          rx_s,
    input logic          overrun
);
    p_halt_on_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cts_auto && start_ok && fifo_count >= trig_lvl) |=> (!cts_auto || cts_n));

    p_resume_below_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cts_auto && fifo_count < trig_lvl) |=> (!cts_auto || !cts_n));

    p_start_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start_ok |-> !rx_s);

    p_seven_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !word8) |-> (push_data[7] == 1'b0));

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CW'(DEPTH));

    p_overrun_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> (fifo_count == CW'(DEPTH)));
endmodule

bind uart_rx_cts uart_rx_cts_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cts_auto(cts_auto), .cts_n(cts_n),
    .trig_lvl(trig_lvl), .fifo_count(fifo_count), .start_ok(start_ok),
    .push(push), .push_data(push_char.data), .word8(word8),
    .rx_s(rx_s), .overrun(overrun)
);

// File: tb/uart_rx_cts_test.sv
module uart_rx_cts_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b1;
    logic       rx_en = 1'b0;
    logic       rx_in = 1'b1;
    logic       word8 = 1'b1;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       cts_auto = 1'b0;
    logic       cts_sw = 1'b0;
    logic [5:0] trig_lvl = 6'd0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       rd_par_err, rd_frm_err, fifo_empty, overrun, cts_n;
    logic [5:0] fifo_count;

    int errors = 0;
    int checks = 0;
    int ovr_cnt = 0;
    bit drain = 1'b0;
    bit done = 1'b0;
    logic [9:0] expq[$];

    always #5 clk = ~clk;

    uart_rx_cts uut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rx_en(rx_en),
        .rx_in(rx_in), .word8(word8), .par_en(par_en), .par_odd(par_odd),
        .cts_auto(cts_auto), .cts_sw(cts_sw), .trig_lvl(trig_lvl),
        .rd_en(rd_en), .rd_data(rd_data), .rd_par_err(rd_par_err),
        .rd_frm_err(rd_frm_err), .fifo_empty(fifo_empty),
        .fifo_count(fifo_count), .overrun(overrun), .cts_n(cts_n)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_char(input logic [7:0] d, input bit w8, input bit pen,
                             input bit podd, input bit bad_par, input bit stop_v,
                             input int nstop, input bit stored);
        logic [7:0] ed;
        logic       pb;
        int         nb;
        nb = w8 ? 8 : 7;
        ed = w8 ? d : {1'b0, d[6:0]};
        pb = (^ed) ^ podd ^ bad_par;
        if (stored) expq.push_back({!stop_v, pen & bad_par, ed});
        rx_in = 1'b0;
        repeat (16) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            rx_in = d[i];
            repeat (16) @(negedge clk);
        end
        if (pen) begin
            rx_in = pb;
            repeat (16) @(negedge clk);
        end
        rx_in = stop_v;
        repeat (16) @(negedge clk);
        rx_in = 1'b1;
        repeat (16 * nstop) @(negedge clk);
    endtask

    // monitor: pops the queue head and compares with the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (drain && !fifo_empty) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R11 unexpected entry", rd_data, 0);
                end else begin
                    logic [9:0] e;
                    e = expq.pop_front();
                    check(rd_data == e[7:0], "R7/R11 data", rd_data, e[7:0]);
                    check(rd_par_err == e[8], "R9 parity flag", rd_par_err, e[8]);
                    check(rd_frm_err == e[9], "R8 framing flag", rd_frm_err, e[9]);
                end
                rd_en = 1'b1;
                @(negedge clk);
                rd_en = 1'b0;
            end
        end
    end

    always @(negedge clk) if (overrun) ovr_cnt++;

    initial begin
        repeat (150000) @(negedge clk);
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        check(cts_n == 1'b1, "R1 cts_n after reset", cts_n, 1);
        check(fifo_empty == 1'b1 && fifo_count == 0, "R1 empty after reset", fifo_count, 0);
        check(overrun == 1'b0, "R1 overrun after reset", overrun, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        rx_en = 1'b1;
        drain = 1'b1;
        repeat (20) @(negedge clk);

        // R7 8-bit and 7-bit
        send_char(8'hA5, 1, 0, 0, 0, 1, 1, 1);
        send_char(8'h3C, 1, 0, 0, 0, 1, 1, 1);
        word8 = 1'b0;
        send_char(8'hDA, 0, 0, 0, 0, 1, 1, 1);
        word8 = 1'b1;
        // R9 parity, with two stop bits for R8
        par_en = 1'b1;
        send_char(8'h03, 1, 1, 0, 0, 1, 2, 1);
        send_char(8'h03, 1, 1, 0, 1, 1, 2, 1);
        par_odd = 1'b1;
        send_char(8'h07, 1, 1, 1, 0, 1, 1, 1);
        send_char(8'h07, 1, 1, 1, 1, 1, 1, 1);
        par_en = 1'b0;
        par_odd = 1'b0;
        // R8 framing error
        send_char(8'h81, 1, 0, 0, 0, 0, 1, 1);
        repeat (40) @(negedge clk);
        check(expq.size() == 0, "R11 all characters read", expq.size(), 0);

        // R6 line low at enable
        rx_en = 1'b0;
        rx_in = 1'b0;
        repeat (5) @(negedge clk);
        rx_en = 1'b1;
        repeat (300) @(negedge clk);
        rx_in = 1'b1;
        repeat (50) @(negedge clk);
        check(fifo_empty == 1'b1, "R6 low line at enable ignored", fifo_count, 0);
        // R6 short glitch
        rx_in = 1'b0;
        repeat (4) @(negedge clk);
        rx_in = 1'b1;
        repeat (300) @(negedge clk);
        check(fifo_empty == 1'b1 && expq.size() == 0, "R6 glitch ignored", fifo_count, 0);

        // R2 software mode
        cts_sw = 1'b1;
        @(negedge clk);
        check(cts_n == 1'b0, "R2 sw request low", cts_n, 0);
        cts_sw = 1'b0;
        @(negedge clk);
        check(cts_n == 1'b1, "R2 sw request high", cts_n, 1);

        // automatic mode, reads stopped
        drain = 1'b0;
        trig_lvl = 6'd4;
        cts_auto = 1'b1;
        repeat (2) @(negedge clk);
        check(cts_n == 1'b0, "R5 auto below trigger", cts_n, 0);
        cts_sw = 1'b1;
        @(negedge clk);
        cts_sw = 1'b0;
        @(negedge clk);
        check(cts_n == 1'b0, "R2 sw ignored in auto", cts_n, 0);
        for (int k = 0; k < 4; k++) send_char(8'(8'h10 + k), 1, 0, 0, 0, 1, 1, 1);
        check(fifo_count == 4, "R3 count at trigger", fifo_count, 4);
        check(cts_n == 1'b0, "R3 not negated at trigger count", cts_n, 0);
        send_char(8'h20, 1, 0, 0, 0, 1, 1, 1);
        check(cts_n == 1'b1, "R3 negated on next start", cts_n, 1);
        check(fifo_count == 5, "R4 stored after negation", fifo_count, 5);
        for (int k = 0; k < 27; k++) send_char(8'(8'h40 + k), 1, 0, 0, 0, 1, 1, 1);
        check(fifo_count == 32, "R4 filled to 32", fifo_count, 32);
        send_char(8'hEE, 1, 0, 0, 0, 1, 1, 0);
        check(fifo_count == 32, "R10 count held when full", fifo_count, 32);
        check(ovr_cnt == 1, "R10 one overrun pulse", ovr_cnt, 1);
        check(cts_n == 1'b1, "R3 still negated when full", cts_n, 1);

        drain = 1'b1;
        repeat (200) @(negedge clk);
        check(expq.size() == 0 && fifo_empty, "R10/R11 stored entries intact", expq.size(), 0);
        check(cts_n == 1'b0, "R5 reasserted after drain", cts_n, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule